// File: doc/BRIEF.md
# Byte-Wide Audio Sample Buffer Interface

This block sits between an 8-bit register bus and the shifter of a serial audio port. It holds one 16-bit transmit sample and one 16-bit received sample. Software reaches each sample as two bytes, selected by a one-bit byte address: 0 for bits 7:0, 1 for bits 15:8. Two request flags tell software when to act. One flag asks for a new transmit sample. The other says a received sample is waiting.

A write to the high byte commits the transmit sample. The low byte is staged first. If no low-byte write came in since the last commit, the low half of the new sample is forced to zero. A read of the high byte releases the receive buffer. A received sample that arrives while the buffer is still full replaces the old one and raises an overrun flag. A separate low-power-exit reset clears the data holding registers and leaves the flags as they are.

Top module: `audio_sample_regs`

## Requirements
- R1: After the synchronous reset `rst`, the outputs are: `tx_irq`=1, `rx_irq`=0, `rx_overrun`=0 and `tx_sample`=0x0000. `bus_rdata` reads 0x00 at both byte addresses.
- R2: A bus write to byte address 1 loads `tx_sample` on the next clock edge. Its bits 15:8 take the written byte and its bits 7:0 take the staged low byte. `tx_irq` goes to 0. A write to byte address 0 only stages the byte: `tx_sample` and `tx_irq` do not change.
- R3: If there was no write to byte address 0 since the previous high-byte commit, or since reset, a high-byte write commits bits 7:0 as 0x00.
- R4: `tx_load` sets `tx_irq` to 1 on the next edge. If `tx_load` and a high-byte write happen in the same cycle, the sample is still committed and `tx_irq` ends at 1.
- R5: `rx_valid` stores `rx_data` and sets `rx_irq` on the next edge. `bus_rdata` is combinational from `bus_addr`: address 0 returns the held bits 7:0 and address 1 returns bits 15:8.
- R6: A read strobe at byte address 1 clears `rx_irq` and `rx_overrun` on the next edge. A read strobe at byte address 0 changes no flag.
- R7: If `rx_valid` arrives while `rx_irq` is 1 and the high byte is not being read, the new sample overwrites the held one and `rx_overrun` becomes 1.
- R8: If `rx_valid` and a high-byte read happen in the same cycle, the new sample is stored, `rx_irq` stays 1 and `rx_overrun` ends at 0.
- R9: `lp_rst` clears `tx_sample`, the staged low byte and the held receive sample to zero on the next edge. It leaves `tx_irq`, `rx_irq` and `rx_overrun` unchanged. A bus write or `rx_valid` in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_rst | input | 1 | Low-power-exit reset of the data registers |
| bus_addr | input | 1 | Byte select: 0 low byte, 1 high byte |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (selected byte of the held receive sample) |
| rx_valid | input | 1 | A received sample is present on rx_data |
| rx_data | input | 16 | Received sample |
| tx_load | input | 1 | Shifter has taken the transmit sample |
| tx_sample | output | 16 | Committed transmit sample |
| tx_irq | output | 1 | Transmit buffer empty request |
| rx_irq | output | 1 | Receive buffer full request |
| rx_overrun | output | 1 | A held sample was overwritten before release |

## Verification
Hard cases are collisions in one clock edge. One is a sample arriving in the same cycle as the high-byte release. Another is the shifter load landing in the same cycle as a commit. The stimulus drives both strobes in a single cycle and then checks the flags and the stored data. The auto-clear rule needs commit history, so the sequence gives two high-byte commits back to back, then a fresh low write, then another bare commit. Low-power-exit reset is issued while a low byte is staged, and the next commit must come out with a zero low half.

// File: rtl/asb_pkg.sv
package asb_pkg;

    typedef enum logic {
        SEL_LO = 1'b0,
        SEL_HI = 1'b1
    } byte_sel_e;

    typedef struct packed {
        logic wr_lo;
        logic wr_hi;
        logic rd_lo;
        logic rd_hi;
    } bus_dec_t;

    function automatic bus_dec_t decode_bus(input logic wr, input logic rd,
                                            input byte_sel_e sel);
        bus_dec_t d;
        d.wr_lo = wr && (sel == SEL_LO);
        d.wr_hi = wr && (sel == SEL_HI);
        d.rd_lo = rd && (sel == SEL_LO);
        d.rd_hi = rd && (sel == SEL_HI);
        return d;
    endfunction

endpackage

// File: rtl/asb_tx_hold.sv
module asb_tx_hold #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lp_rst,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic                tx_load,
    output logic [2*BYTE_W-1:0] tx_sample,
    output logic                tx_irq
);
    localparam int SAMPLE_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] lo_stage;
    logic              lo_fresh;
    logic              commit;
    logic [BYTE_W-1:0] lo_eff;

    assign commit = wr_hi && !lp_rst;
    assign lo_eff = lo_fresh ? lo_stage : '0;

    always_ff @(posedge clk) begin
        if (rst || lp_rst) begin
            lo_stage  <= '0;
            lo_fresh  <= 1'b0;
            tx_sample <= '0;
        end else if (wr_lo) begin
            lo_stage <= wdata;
            lo_fresh <= 1'b1;
        end else if (commit) begin
            tx_sample <= SAMPLE_W'({wdata, lo_eff});
            lo_fresh  <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          tx_irq <= 1'b1;
        else if (tx_load) tx_irq <= 1'b1;
        else if (commit)  tx_irq <= 1'b0;
    end
endmodule

// File: rtl/asb_rx_hold.sv
module asb_rx_hold #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lp_rst,
    input  logic                rx_valid,
    input  logic [2*BYTE_W-1:0] rx_data,
    input  logic                rd_hi,
    output logic [2*BYTE_W-1:0] held,
    output logic                rx_irq,
    output logic                rx_overrun
);
    logic arrive;
    assign arrive = rx_valid && !lp_rst;

    always_ff @(posedge clk) begin
        if (rst || lp_rst) held <= '0;
        else if (arrive)   held <= rx_data;
    end

    always_ff @(posedge clk) begin
        if (rst)         rx_irq <= 1'b0;
        else if (arrive) rx_irq <= 1'b1;
        else if (rd_hi)  rx_irq <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)                               rx_overrun <= 1'b0;
        else if (arrive && rx_irq && !rd_hi)   rx_overrun <= 1'b1;
        else if (rd_hi)                        rx_overrun <= 1'b0;
    end
endmodule

// File: rtl/asb_rd_mux.sv
module asb_rd_mux #(
    parameter int BYTE_W = 8
) (
    input  logic                sel_hi,
    input  logic [2*BYTE_W-1:0] held,
    output logic [BYTE_W-1:0]   rdata
);
    always_comb begin
        if (sel_hi) rdata = held[2*BYTE_W-1:BYTE_W];
        else        rdata = held[BYTE_W-1:0];
    end
endmodule

// File: rtl/audio_sample_regs.sv
module audio_sample_regs #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lp_rst,
    input  logic                bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    input  logic                rx_valid,
    input  logic [2*BYTE_W-1:0] rx_data,
    input  logic                tx_load,
    output logic [2*BYTE_W-1:0] tx_sample,
    output logic                tx_irq,
    output logic                rx_irq,
    output logic                rx_overrun
);
    import asb_pkg::*;

    localparam int SAMPLE_W = 2 * BYTE_W;

    bus_dec_t            dec;
    logic [SAMPLE_W-1:0] rx_held;

    assign dec = decode_bus(bus_wr, bus_rd, byte_sel_e'(bus_addr));

    asb_tx_hold #(.BYTE_W(BYTE_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .lp_rst    (lp_rst),
        .wr_lo     (dec.wr_lo),
        .wr_hi     (dec.wr_hi),
        .wdata     (bus_wdata),
        .tx_load   (tx_load),
        .tx_sample (tx_sample),
        .tx_irq    (tx_irq)
    );

    asb_rx_hold #(.BYTE_W(BYTE_W)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .lp_rst     (lp_rst),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rd_hi      (dec.rd_hi),
        .held       (rx_held),
        .rx_irq     (rx_irq),
        .rx_overrun (rx_overrun)
    );

    asb_rd_mux #(.BYTE_W(BYTE_W)) u_mux (
        .sel_hi (bus_addr),
        .held   (rx_held),
        .rdata  (bus_rdata)
    );
endmodule

// File: rtl/asb_checker.sv
module asb_checker #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                lp_rst,
    input logic                bus_addr,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [BYTE_W-1:0]   bus_wdata,
    input logic                rx_valid,
    input logic                tx_load,
    input logic [2*BYTE_W-1:0] tx_sample,
    input logic                tx_irq,
    input logic                rx_irq,
    input logic                rx_overrun
);
    // R2
    hi_commit_clears_txirq_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr && !lp_rst && !tx_load) |=> !tx_irq);

    // R2
    hi_commit_data_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr && !lp_rst) |=> (tx_sample[2*BYTE_W-1:BYTE_W] == $past(bus_wdata)));

    // R4
    load_sets_txirq_chk: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> tx_irq);

    // R5
    arrive_sets_rxirq_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !lp_rst) |=> rx_irq);

    // R6
    hi_read_releases_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr && !rx_valid) |=> (!rx_irq && !rx_overrun));

    // R7
    overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !lp_rst && rx_irq && !(bus_rd && bus_addr)) |=> rx_overrun);

    // R9
    lp_clears_tx_chk: assert property (@(posedge clk) disable iff (rst)
        lp_rst |=> (tx_sample == '0));

    // R9
    lp_keeps_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (lp_rst && !tx_load && !(bus_rd && bus_addr)) |=> ($stable(tx_irq) && $stable(rx_irq) && $stable(rx_overrun)));
endmodule

bind audio_sample_regs asb_checker #(.BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lp_rst     (lp_rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .rx_valid   (rx_valid),
    .tx_load    (tx_load),
    .tx_sample  (tx_sample),
    .tx_irq     (tx_irq),
    .rx_irq     (rx_irq),
    .rx_overrun (rx_overrun)
);

// File: tb/tb_audio_sample_regs.sv
module tb_audio_sample_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lp_rst = 1'b0;
    logic        bus_addr = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        rx_valid = 1'b0;
    logic [15:0] rx_data = '0;
    logic        tx_load = 1'b0;
    logic [15:0] tx_sample;
    logic        tx_irq, rx_irq, rx_overrun;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    typedef enum int { OBS_TXS, OBS_TXI, OBS_RXI, OBS_OVR, OBS_RD } obs_e;
    typedef struct {
        obs_e        what;
        logic [15:0] exp;
        string       req;
    } exp_t;

    exp_t sb[$];
    event chk_ev;

    always #5 clk = ~clk;

    audio_sample_regs dut (
        .clk(clk), .rst(rst), .lp_rst(lp_rst), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_load(tx_load), .tx_sample(tx_sample), .tx_irq(tx_irq),
        .rx_irq(rx_irq), .rx_overrun(rx_overrun)
    );

    // Monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (sb.size() > 0) begin
                exp_t e;
                logic [15:0] act;
                e = sb.pop_front();
                case (e.what)
                    OBS_TXS: act = tx_sample;
                    OBS_TXI: act = {15'd0, tx_irq};
                    OBS_RXI: act = {15'd0, rx_irq};
                    OBS_OVR: act = {15'd0, rx_overrun};
                    default: act = {8'd0, bus_rdata};
                endcase
                checks++;
                if (act !== e.exp) begin
                    failures++;
                    $display("FAIL %s %s actual=%h expected=%h", e.req, e.what.name(), act, e.exp);
                end
            end
        end
    end

    task automatic expect_val(input obs_e w, input logic [15:0] v, input string req);
        exp_t e;
        e.what = w; e.exp = v; e.req = req;
        sb.push_back(e);
    endtask

    task automatic sync_chk();
        ->chk_ev;
        #1;
    endtask

    // Driver: one clock of stimulus, outputs settled 1 ns after the edge
    task automatic drive(input logic wr, input logic rd, input logic a,
                         input logic [7:0] wd, input logic rv,
                         input logic [15:0] rd_in, input logic tl, input logic lp);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        rx_valid = rv; rx_data = rd_in; tx_load = tl; lp_rst = lp;
        @(posedge clk);
        #1;
        bus_wr = 0; bus_rd = 0; rx_valid = 0; tx_load = 0; lp_rst = 0;
    endtask

    task automatic peek(input logic a, input logic [7:0] v, input string req);
        bus_addr = a;
        #1;
        expect_val(OBS_RD, {8'd0, v}, req);
        sync_chk();
    endtask

    task automatic flags(input logic ti, input logic ri, input logic ov, input string req);
        expect_val(OBS_TXI, {15'd0, ti}, req);
        expect_val(OBS_RXI, {15'd0, ri}, req);
        expect_val(OBS_OVR, {15'd0, ov}, req);
        sync_chk();
    endtask

    task automatic txs(input logic [15:0] v, input string req);
        expect_val(OBS_TXS, v, req);
        sync_chk();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        flags(1, 0, 0, "R1");
        txs(16'h0000, "R1");
        peek(0, 8'h00, "R1");
        peek(1, 8'h00, "R1");

        // R2 low write only stages
        drive(1, 0, 0, 8'h34, 0, 0, 0, 0);
        txs(16'h0000, "R2");
        flags(1, 0, 0, "R2");
        drive(1, 0, 1, 8'h12, 0, 0, 0, 0);
        txs(16'h1234, "R2");
        flags(0, 0, 0, "R2");

        // R4 shifter load
        drive(0, 0, 0, 0, 0, 0, 1, 0);
        flags(1, 0, 0, "R4");

        // R3 bare commit clears low half
        drive(1, 0, 1, 8'h56, 0, 0, 0, 0);
        txs(16'h5600, "R3");
        drive(1, 0, 0, 8'h78, 0, 0, 0, 0);
        drive(1, 0, 1, 8'h9A, 0, 0, 0, 0);
        txs(16'h9A78, "R3");
        drive(1, 0, 1, 8'hBC, 0, 0, 0, 0);
        txs(16'hBC00, "R3");

        // R4 load and commit in the same cycle
        drive(1, 0, 0, 8'h11, 0, 0, 0, 0);
        drive(1, 0, 1, 8'hDE, 0, 0, 1, 0);
        txs(16'hDE11, "R4");
        flags(1, 0, 0, "R4");

        // R5 receive and read bytes
        drive(0, 0, 0, 0, 1, 16'hA55A, 0, 0);
        flags(1, 1, 0, "R5");
        peek(0, 8'h5A, "R5");
        peek(1, 8'hA5, "R5");

        // R6 low read leaves flags
        drive(0, 1, 0, 0, 0, 0, 0, 0);
        flags(1, 1, 0, "R6");

        // R7 overrun
        drive(0, 0, 0, 0, 1, 16'h1357, 0, 0);
        flags(1, 1, 1, "R7");
        peek(0, 8'h57, "R7");
        peek(1, 8'h13, "R7");

        // R6 high read releases
        drive(0, 1, 1, 0, 0, 0, 0, 0);
        flags(1, 0, 0, "R6");

        // R8 arrival with same-cycle release
        drive(0, 0, 0, 0, 1, 16'h2468, 0, 0);
        drive(0, 1, 1, 0, 1, 16'h1111, 0, 0);
        flags(1, 1, 0, "R8");
        peek(1, 8'h11, "R8");

        // R9 low-power-exit reset
        drive(1, 0, 0, 8'h77, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 0, 1);
        txs(16'h0000, "R9");
        flags(1, 1, 0, "R9");
        peek(0, 8'h00, "R9");
        peek(1, 8'h00, "R9");
        drive(1, 0, 1, 8'h22, 0, 0, 0, 0);
        txs(16'h2200, "R9");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule